// File: doc/BRIEF.md
# Command-to-APB Burst Bridge

This block turns commands from an internal command port into single-word APB transfers. A command carries a byte address, a direction and a word count. A write command first fetches all of its data words over a request/grant pull interface into a local FIFO. The bridge then issues one APB write per word. A read command issues one APB read per word, and the bridge hands each returned word to a request/grant push interface before it starts the next read.

The upper address bits pick one of up to fifteen peripherals, and each peripheral has its own select line. An address whose device field has no peripheral behind it finishes at once and no select goes high. Each APB access has a one-cycle setup phase and then an access phase. The access phase lasts until the peripheral raises its ready input. Successive words of a burst go to addresses four bytes apart.

States of the sequencer: `ST_IDLE` (command port ready), `ST_PULL` (loading write words), `ST_SETUP` (select high, enable low), `ST_ACCESS` (enable high, waiting for ready) and `ST_PUSH` (read word offered on the push port). The transitions are:
- IDLE→PULL on a write command, and IDLE→SETUP on a read command.
- PULL→SETUP when the last write word is taken.
- SETUP→ACCESS on a decode hit. On a miss, SETUP completes the word at once.
- ACCESS completes the word on ready.
- A completed read word goes to PUSH. A completed write word goes to SETUP if words remain, otherwise to IDLE.
- PUSH→SETUP on grant if words remain, otherwise PUSH→IDLE.

Top module: `cmd_apb_bridge`

## Requirements
- R1: For a write command, `pull_req` stays high until all of the command's words have been taken (a word is taken on a cycle with `pull_req`, `pull_gnt` and `pull_valid` all high). No APB select is asserted while `pull_req` is high.
- R2: The device index is address bits [15:12]. Index 0 to 14 raises only `apb_sel[index]`. At most one select bit is ever high.
- R3: Every mapped transfer spends one cycle with select high and `apb_enable` low. It then holds `apb_enable` high with address, select and write direction unchanged until the cycle in which `apb_ready` is high.
- R4: `apb_enable` is low for at least one cycle after any cycle in which it was high together with `apb_ready`.
- R5: A command of length N issues N word transfers at addresses base, base+4, base+8 and so on, modulo 2^16. A length of 0 behaves as 1.
- R6: For a read, the word sampled on `apb_rdata` at the completing cycle is presented on `push_data` with `push_req` high. It is held until `push_gnt`, and the words arrive in address order.
- R7: For a write, `apb_wdata` of the k-th word equals the k-th word taken from the pull interface.
- R8: Device index 15 is unmapped. Such a word raises no select and no enable. A write word to it is discarded, and a read word from it returns 0 on `push_data`.
- R9: `cmd_ready` is high only while no command is in progress. A new command is accepted only after the previous command's last word has completed.
- R10: After reset, `cmd_ready` is 1 and `pull_req`, `push_req`, `apb_sel` and `apb_enable` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Bridge idle, command accepted when valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Byte address of first word |
| cmd_len | input | 4 | Word count (0 treated as 1) |
| pull_req | output | 1 | Request for write data |
| pull_gnt | input | 1 | Pull bus granted |
| pull_valid | input | 1 | Pull word present |
| pull_data | input | 32 | Pull word |
| push_req | output | 1 | Read word offered |
| push_gnt | input | 1 | Read word taken |
| push_data | output | 32 | Read word |
| apb_addr | output | 16 | APB address |
| apb_sel | output | 15 | Per-device select lines |
| apb_enable | output | 1 | APB enable |
| apb_write | output | 1 | APB direction |
| apb_wdata | output | 32 | APB write data |
| apb_rdata | input | 32 | APB read data |
| apb_ready | input | 1 | Peripheral ready |

## Verification
A wrong word counter shows up on the APB side, as too many or too few transfers. It also shows as `cmd_ready` returning at the wrong time, within one burst. A sequencer that skips its setup state or keeps enable high across a completion breaks the phase rules on the very next clock. A stale address register or stale FIFO pointer gives the wrong address or wrong data on the next transfer. The bench compares every transfer and every pushed word against values it computes itself. It also watches the phase, select and stall rules on every cycle, so such faults are caught within a cycle or at the end of the command in which they occur. Bursts that cross a device boundary, or run into the unmapped index, check that the decode follows the incremented address.

// File: rtl/cab_pkg.sv
package cab_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULL,
        ST_SETUP,
        ST_ACCESS,
        ST_PUSH
    } cab_state_e;
endpackage

// File: rtl/cab_pull_fifo.sv
module cab_pull_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr_q, rptr_q;
    logic [AW:0]       count_q;
    logic              full, empty;

    assign full    = (count_q == (AW+1)'(DEPTH));
    assign empty   = (count_q == '0);
    assign rd_data = mem[rptr_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (wr_en) wptr_q <= wptr_q + AW'(1);
            if (rd_en) rptr_q <= rptr_q + AW'(1);
            unique case ({wr_en, rd_en})
                2'b10:   count_q <= count_q + (AW+1)'(1);
                2'b01:   count_q <= count_q - (AW+1)'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr_q] <= wr_data;
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/cab_sel_decode.sv
module cab_sel_decode #(
    parameter int ADDR_W = 16,
    parameter int DEV_W  = 4,
    parameter int N_DEV  = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_en,
    output logic              hit,
    output logic [N_DEV-1:0]  sel
);
    logic [DEV_W-1:0] dev_idx;

    assign dev_idx = addr[ADDR_W-1 -: DEV_W];
    assign hit     = (int'(dev_idx) < N_DEV);

    for (genvar g = 0; g < N_DEV; g++) begin : g_sel
        assign sel[g] = sel_en && (dev_idx == DEV_W'(g));
    end
endmodule

// File: rtl/cab_seq.sv
module cab_seq
    import cab_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_ready,
    output logic              pull_req,
    input  logic              pull_gnt,
    input  logic              pull_valid,
    output logic              fifo_wr,
    output logic              fifo_rd,
    output logic              push_req,
    input  logic              push_gnt,
    output logic [DATA_W-1:0] push_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic              bus_enable,
    output logic              sel_en,
    input  logic              dev_hit,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int STEP = DATA_W / 8;

    cab_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [LEN_W-1:0]  left_q, pulled_q;
    logic [DATA_W-1:0] rdata_q;
    logic              take, word_done, last, step;

    assign take      = (state_q == ST_PULL) && pull_gnt && pull_valid;
    assign word_done = ((state_q == ST_SETUP) && !dev_hit) ||
                       ((state_q == ST_ACCESS) && bus_ready);
    assign last      = (left_q == LEN_W'(1));
    assign step      = (word_done && write_q) || ((state_q == ST_PUSH) && push_gnt);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (cmd_valid) state_d = cmd_write ? ST_PULL : ST_SETUP;
            ST_PULL:
                if (take && (pulled_q == left_q - LEN_W'(1))) state_d = ST_SETUP;
            ST_SETUP:
                if (dev_hit)      state_d = ST_ACCESS;
                else if (!write_q) state_d = ST_PUSH;
                else              state_d = last ? ST_IDLE : ST_SETUP;
            ST_ACCESS:
                if (bus_ready) begin
                    if (!write_q) state_d = ST_PUSH;
                    else          state_d = last ? ST_IDLE : ST_SETUP;
                end
            ST_PUSH:
                if (push_gnt) state_d = last ? ST_IDLE : ST_SETUP;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready  = (state_q == ST_IDLE);
        pull_req   = (state_q == ST_PULL);
        push_req   = (state_q == ST_PUSH);
        sel_en     = (state_q == ST_SETUP) || (state_q == ST_ACCESS);
        bus_enable = (state_q == ST_ACCESS);
        bus_write  = write_q && sel_en;
        bus_addr   = addr_q;
        push_data  = rdata_q;
        fifo_wr    = take;
        fifo_rd    = word_done && write_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            write_q  <= 1'b0;
            left_q   <= '0;
            pulled_q <= '0;
            rdata_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && cmd_valid) begin
                addr_q   <= cmd_addr;
                write_q  <= cmd_write;
                left_q   <= (cmd_len == '0) ? LEN_W'(1) : cmd_len;
                pulled_q <= '0;
            end
            if (take) pulled_q <= pulled_q + LEN_W'(1);
            if (word_done && !write_q) rdata_q <= dev_hit ? bus_rdata : '0;
            if (step) begin
                left_q <= left_q - LEN_W'(1);
                addr_q <= addr_q + ADDR_W'(STEP);
            end
        end
    end

    a_r1_pull_before_bus: assert property (@(posedge clk) disable iff (!rst_n)
        pull_req |-> !sel_en);
    a_r3_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_enable) |-> ($past(sel_en) && $stable(bus_addr)));
    a_r3_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_enable && !bus_ready) |=> (bus_enable && $stable(bus_addr) && $stable(bus_write)));
    a_r4_enable_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_enable && bus_ready) |=> !bus_enable);
    a_r6_push_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !push_gnt) |=> (push_req && $stable(push_data)));
    a_r8_miss_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_en && !bus_enable && !dev_hit) |=> !bus_enable);
    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!sel_en && !pull_req && !push_req));
endmodule

// File: rtl/cmd_apb_bridge.sv
module cmd_apb_bridge #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 4,
    parameter int DEV_W  = 4,
    parameter int N_DEV  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              pull_req,
    input  logic              pull_gnt,
    input  logic              pull_valid,
    input  logic [DATA_W-1:0] pull_data,
    output logic              push_req,
    input  logic              push_gnt,
    output logic [DATA_W-1:0] push_data,
    output logic [ADDR_W-1:0] apb_addr,
    output logic [N_DEV-1:0]  apb_sel,
    output logic              apb_enable,
    output logic              apb_write,
    output logic [DATA_W-1:0] apb_wdata,
    input  logic [DATA_W-1:0] apb_rdata,
    input  logic              apb_ready
);
    localparam int FIFO_DEPTH = 2 ** LEN_W;

    logic fifo_wr, fifo_rd, sel_en, dev_hit;

    cab_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_ready(cmd_ready),
        .pull_req(pull_req), .pull_gnt(pull_gnt), .pull_valid(pull_valid),
        .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
        .push_req(push_req), .push_gnt(push_gnt), .push_data(push_data),
        .bus_addr(apb_addr), .bus_write(apb_write), .bus_enable(apb_enable),
        .sel_en(sel_en), .dev_hit(dev_hit),
        .bus_ready(apb_ready), .bus_rdata(apb_rdata)
    );

    cab_pull_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(fifo_wr), .wr_data(pull_data),
        .rd_en(fifo_rd), .rd_data(apb_wdata)
    );

    cab_sel_decode #(.ADDR_W(ADDR_W), .DEV_W(DEV_W), .N_DEV(N_DEV)) u_dec (
        .addr(apb_addr), .sel_en(sel_en), .hit(dev_hit), .sel(apb_sel)
    );

    a_r2_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(apb_sel));
    a_r8_enable_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        apb_enable |-> (apb_sel != '0));
endmodule

// File: tb/cmd_apb_bridge_test.sv
`timescale 1ns/1ps
module cmd_apb_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [3:0]  cmd_len = '0;
    logic        cmd_ready, pull_req, push_req, apb_enable, apb_write;
    logic        pull_gnt = 1'b0, pull_valid = 1'b0, push_gnt = 1'b0, apb_ready = 1'b0;
    logic [31:0] pull_data = '0, apb_rdata = '0, push_data, apb_wdata;
    logic [15:0] apb_addr;
    logic [14:0] apb_sel;

    cmd_apb_bridge uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .pull_req(pull_req), .pull_gnt(pull_gnt), .pull_valid(pull_valid),
        .pull_data(pull_data), .push_req(push_req), .push_gnt(push_gnt),
        .push_data(push_data), .apb_addr(apb_addr), .apb_sel(apb_sel),
        .apb_enable(apb_enable), .apb_write(apb_write), .apb_wdata(apb_wdata),
        .apb_rdata(apb_rdata), .apb_ready(apb_ready)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0;
    int cmd_no = 0, wait_cfg = 0, wcnt = 0, pull_idx = 0, n_apb = 0, n_push = 0;
    int v_r1 = 0, v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r9 = 0;
    logic [15:0] log_addr [32];
    logic [14:0] log_sel  [32];
    logic        log_wr   [32];
    logic [31:0] log_wd   [32];
    logic [31:0] log_push [32];
    logic        p_en = 0, p_rdy = 0;
    logic [14:0] p_sel = '0;
    logic [15:0] p_addr = '0;

    function automatic logic [31:0] pat(int c, int k);
        return 32'hD000_0000 | (c << 8) | k;
    endfunction
    function automatic logic [31:0] rd_val(logic [15:0] a);
        return {a ^ 16'h5A5A, a};
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // peripheral, pull and push models plus phase monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            apb_ready <= 0; pull_gnt <= 0; pull_valid <= 0; push_gnt <= 0;
            p_en <= 0; p_rdy <= 0; p_sel <= '0;
        end else begin
            if ($countones(apb_sel) > 1) v_r2++;
            if (apb_sel != '0 && pull_req) v_r1++;
            if (apb_enable && !p_en && (p_sel == '0 || p_sel != apb_sel || p_addr != apb_addr)) v_r3++;
            if (apb_enable && p_en && (p_sel != apb_sel || p_addr != apb_addr)) v_r3++;
            if (p_en && p_rdy && apb_enable) v_r4++;
            if (cmd_ready && (pull_req || push_req || apb_sel != '0)) v_r9++;
            p_en <= apb_enable; p_sel <= apb_sel; p_addr <= apb_addr;
            apb_rdata <= rd_val(apb_addr);
            if (apb_enable) begin
                if (wcnt == 0) begin
                    apb_ready <= 1; p_rdy <= 1;
                    log_addr[n_apb] = apb_addr; log_sel[n_apb] = apb_sel;
                    log_wr[n_apb] = apb_write; log_wd[n_apb] = apb_wdata;
                    n_apb++;
                end else begin
                    wcnt--; apb_ready <= 0; p_rdy <= 0;
                end
            end else begin
                apb_ready <= 0; p_rdy <= 0; wcnt = wait_cfg;
            end
            if (pull_gnt && pull_valid) pull_idx++;
            if (pull_req) begin
                pull_gnt <= 1; pull_valid <= 1; pull_data <= pat(cmd_no, pull_idx);
            end else begin
                pull_gnt <= 0; pull_valid <= 0;
            end
            if (push_gnt) push_gnt <= 0;
            else if (push_req) begin
                log_push[n_push] = push_data; n_push++; push_gnt <= 1;
            end
        end
    end

    // {write, addr[15:0], len[3:0], wait[3:0]}
    localparam logic [24:0] VEC [9] = '{
        {1'b1, 16'h1000, 4'd1, 4'd0},
        {1'b0, 16'h2010, 4'd3, 4'd1},
        {1'b1, 16'h3000, 4'd4, 4'd2},
        {1'b0, 16'h0FF8, 4'd4, 4'd0},
        {1'b1, 16'hF000, 4'd2, 4'd0},
        {1'b0, 16'hF100, 4'd2, 4'd1},
        {1'b1, 16'hE004, 4'd0, 4'd1},
        {1'b0, 16'h5000, 4'd0, 4'd3},
        {1'b1, 16'hEFF8, 4'd3, 4'd0}
    };

    task automatic wait_idle(string tag);
        int n = 0;
        while (!cmd_ready && n < 2000) begin @(negedge clk); n++; end
        check(cmd_ready, tag, 32'(cmd_ready), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(cmd_ready == 1, "R10 cmd_ready", 32'(cmd_ready), 1);
        check(apb_sel == 0 && !apb_enable, "R10 apb idle", {apb_sel, apb_enable}, 0);
        check(!pull_req && !push_req, "R10 req idle", {pull_req, push_req}, 0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < 9; i++) begin
            logic        wr;
            logic [15:0] base, a;
            int          leff, mapped, e;
            wr = VEC[i][24]; base = VEC[i][23:8];
            leff = (VEC[i][7:4] == 0) ? 1 : int'(VEC[i][7:4]);
            cmd_no = i; wait_cfg = int'(VEC[i][3:0]);
            pull_idx = 0; n_apb = 0; n_push = 0;
            cmd_valid = 1; cmd_write = wr; cmd_addr = base; cmd_len = VEC[i][7:4];
            @(negedge clk);
            cmd_valid = 0;
            check(!cmd_ready, "R9 busy after accept", 32'(cmd_ready), 0);
            wait_idle("R9 returns idle");
            @(negedge clk);
            mapped = 0;
            for (int k = 0; k < leff; k++) begin
                a = base + 16'(4 * k);
                if (a[15:12] != 4'hF) mapped++;
            end
            check(n_apb == mapped, "R5/R8 transfer count", n_apb, mapped);
            if (wr) check(pull_idx == leff, "R1 words pulled", pull_idx, leff);
            else    check(n_push == leff, "R6 words pushed", n_push, leff);
            e = 0;
            for (int k = 0; k < leff; k++) begin
                a = base + 16'(4 * k);
                if (a[15:12] != 4'hF && e < n_apb) begin
                    check(log_addr[e] == a, "R5 address", log_addr[e], a);
                    check(log_sel[e] == 15'(1 << a[15:12]), "R2 select", log_sel[e], 15'(1 << a[15:12]));
                    check(log_wr[e] == wr, "R3 direction", log_wr[e], wr);
                    if (wr) check(log_wd[e] == pat(i, k), "R7 write data", log_wd[e], pat(i, k));
                    e++;
                end
                if (!wr && k < n_push) begin
                    if (a[15:12] == 4'hF)
                        check(log_push[k] == 0, "R8 unmapped read zero", log_push[k], 0);
                    else
                        check(log_push[k] == rd_val(a), "R6 read data", log_push[k], rd_val(a));
                end
            end
        end

        // directed: reset in the middle of a burst
        wait_cfg = 5; pull_idx = 0; n_apb = 0; n_push = 0;
        cmd_valid = 1; cmd_write = 0; cmd_addr = 16'h4000; cmd_len = 4'd6;
        @(negedge clk); cmd_valid = 0;
        repeat (4) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        check(cmd_ready && apb_sel == 0 && !apb_enable && !push_req && !pull_req,
              "R10 mid-burst reset", {cmd_ready, apb_enable}, 32'h2);
        rst_n = 1;
        @(negedge clk);

        check(v_r1 == 0, "R1 select during pull", v_r1, 0);
        check(v_r2 == 0, "R2 multiple selects", v_r2, 0);
        check(v_r3 == 0, "R3 phase violations", v_r3, 0);
        check(v_r4 == 0, "R4 enable gap", v_r4, 0);
        check(v_r9 == 0, "R9 ready while busy", v_r9, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule